// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a watchdog for a 32-bit register bus. Software programs a reload value and enables the timer through a control register. From then on a down-counter decrements either on every bus clock or on a slow tick made by an internal prescaler. Software proves it is alive by writing a 16-bit key to a restart register, which reloads the counter. If the counter reaches zero first, the block raises a one-cycle expiry strobe and an optional interrupt strobe. It then drives a system reset request and an external reset line for a programmed number of slow ticks.

The control register is edge-sensitive on its enable bit: a write only takes effect when it flips that bit. The external reset line's polarity and drive type are changed by writing key codes into the top byte of a pulse-configuration register. The low bits of the same register always hold the pulse width. After expiry the counter stays at zero until software reloads it.

Top module: `wdog_ctrl`

## Requirements
- R1: Register decode on byte addresses: 0x00 current count (read-only), 0x04 reload value, 0x08 restart (write-only, reads 0), 0x0C control (bits 5:0, upper bits read 0), 0x18 pulse configuration. Accesses with address bits 1:0 not zero, and accesses to any other offset, are ignored; such reads return 0. Read data is combinational in the cycle of the read.
- R2: A write to 0x08 whose bits 15:0 equal 0x4755 copies the reload value into the counter at that clock edge, whatever bits 31:16 hold. Any other value leaves the counter untouched.
- R3: Control bits: 0 enable, 1 system reset on expiry, 2 interrupt on expiry, 3 external reset on expiry, 4 slow tick, 5 full-chip mode. With bit 4 clear the counter decrements on every clock. With bit 4 set it decrements once every PRESC_DIV clocks (24 by default), and the prescaler restarts whenever the counter is loaded.
- R4: A control write is stored only when its bit 0 differs from the current enable. A write from 0 to 1 loads the counter from the reload value and starts counting. A write from 1 to 0 freezes the count. A write with an unchanged enable leaves the whole control register as it was.
- R5: A write to 0x18 with top byte 0xA5 sets bit 31 (external reset active high), and 0x5A clears it. A top byte of 0xA8 sets bit 30 (push-pull drive), and 0x8A clears it. Any other top byte leaves bits 31 and 30 unchanged.
- R6: Every write to 0x18 stores bits 19:0 as the pulse width W, whatever the top byte holds. Bits 29:20 read 0. A width of 0 acts as 1.
- R7: After reset, the count and reload registers read 0x03EF1480, control and restart read 0, and the configuration register reads 0x000000FF.
- R8: With reload R and the fast tick, expire_o is high for exactly one cycle, R clock edges after the edge that enables the counter. The count then stays 0 and the counter does not restart by itself.
- R9: irq_o is a one-cycle strobe coincident with expire_o when control bit 2 is set; otherwise it stays low.
- R10: If control bit 1 is set at expiry, sys_rst_o rises one edge after expire_o and stays high for W*PRESC_DIV cycles. sys_rst_full_o mirrors control bit 5 during that window and is 0 otherwise.
- R11: If control bit 3 is set at expiry, the external reset is asserted over the same window. ext_rst_o carries the asserted level given by bit 31 (1 = high) and the opposite level otherwise. ext_rst_oe_o is always 1 with push-pull drive; with open-drain drive it is 1 only while asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| expire_o | output | 1 | One-cycle strobe when the count reaches zero |
| irq_o | output | 1 | One-cycle interrupt strobe on expiry |
| sys_rst_o | output | 1 | System reset request pulse |
| sys_rst_full_o | output | 1 | Full-chip scope qualifier during the reset pulse |
| ext_rst_o | output | 1 | External reset level, polarity programmable |
| ext_rst_oe_o | output | 1 | Output enable for the external reset line |

## Verification
Read data is due in the cycle of the read. A counter load, a control update or a configuration update lands on the clock edge that takes the write. The expiry strobe follows the enabling edge by exactly R edges on the fast tick and by R*PRESC_DIV edges on the slow tick. The reset outputs rise one edge after the strobe and fall W*PRESC_DIV edges later. The bench drives each access in the low half of the clock and counts falling edges from the edge that took the write. It samples each output on the falling edge where that count says the change is due, and on the edge just before it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // byte offsets of the register file
   localparam logic [7:0] OFS_COUNT   = 8'h00;
   localparam logic [7:0] OFS_RELOAD  = 8'h04;
   localparam logic [7:0] OFS_RESTART = 8'h08;
   localparam logic [7:0] OFS_CTRL    = 8'h0C;
   localparam logic [7:0] OFS_PCFG    = 8'h18;

   // restart key in the low half-word
   localparam logic [15:0] RESTART_KEY = 16'h4755;

   // top-byte codes of the pulse configuration register
   localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
   localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
   localparam logic [7:0] KEY_PUSH     = 8'hA8;
   localparam logic [7:0] KEY_OPEN     = 8'h8A;

   // control register, bit 5 down to bit 0
   typedef struct packed {
      logic full_chip;
      logic slow_tick;
      logic ext_en;
      logic irq_en;
      logic sys_en;
      logic enable;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   typedef struct packed {
      logic pol_high;
      logic push_pull;
   } drv_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 8,
   parameter int          CNT_W      = 32,
   parameter int          PW_BITS    = 20,
   parameter logic [31:0] RELOAD_RST = 32'h03EF1480,
   parameter logic [31:0] PW_RST     = 32'h000000FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cur_count_i,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [CNT_W-1:0]  reload_o,
   output ctrl_t             ctrl_o,
   output drv_t              drv_o,
   output logic [PW_BITS-1:0] width_o,
   output logic              load_o
);

   localparam int KEY_LSB = DATA_W - 8;

   logic aligned;
   logic sel_count, sel_reload, sel_restart, sel_ctrl, sel_pcfg;
   logic wr_reload, wr_restart, wr_ctrl, wr_pcfg;
   logic key_ok, en_flip;
   logic [7:0] top_code;

   ctrl_t              ctrl_q;
   drv_t               drv_q;
   logic [CNT_W-1:0]   reload_q;
   logic [PW_BITS-1:0] width_q;

   assign aligned     = (bus_addr[1:0] == 2'b00);
   assign sel_count   = bus_en & aligned & (bus_addr == ADDR_W'(OFS_COUNT));
   assign sel_reload  = bus_en & aligned & (bus_addr == ADDR_W'(OFS_RELOAD));
   assign sel_restart = bus_en & aligned & (bus_addr == ADDR_W'(OFS_RESTART));
   assign sel_ctrl    = bus_en & aligned & (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_pcfg    = bus_en & aligned & (bus_addr == ADDR_W'(OFS_PCFG));

   assign wr_reload  = sel_reload  & bus_we;
   assign wr_restart = sel_restart & bus_we;
   assign wr_ctrl    = sel_ctrl    & bus_we;
   assign wr_pcfg    = sel_pcfg    & bus_we;

   assign key_ok   = (bus_wdata[15:0] == RESTART_KEY);
   assign en_flip  = wr_ctrl & (bus_wdata[0] != ctrl_q.enable);
   assign top_code = bus_wdata[KEY_LSB +: 8];

   // counter load: keyed restart or a rising enable
   assign load_o = (wr_restart & key_ok) | (en_flip & bus_wdata[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RELOAD_RST[CNT_W-1:0];
         ctrl_q   <= '0;
      end else begin
         if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
         if (en_flip)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q   <= '0;
         width_q <= PW_RST[PW_BITS-1:0];
      end else if (wr_pcfg) begin
         width_q <= bus_wdata[PW_BITS-1:0];
         unique case (top_code)
            KEY_POL_HIGH: drv_q.pol_high  <= 1'b1;
            KEY_POL_LOW:  drv_q.pol_high  <= 1'b0;
            KEY_PUSH:     drv_q.push_pull <= 1'b1;
            KEY_OPEN:     drv_q.push_pull <= 1'b0;
            default:      drv_q           <= drv_q;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (!bus_we) begin
         if (sel_count)  bus_rdata = DATA_W'(cur_count_i);
         if (sel_reload) bus_rdata = DATA_W'(reload_q);
         if (sel_ctrl)   bus_rdata[CTRL_W-1:0] = ctrl_q;
         if (sel_pcfg) begin
            bus_rdata[DATA_W-1]    = drv_q.pol_high;
            bus_rdata[DATA_W-2]    = drv_q.push_pull;
            bus_rdata[PW_BITS-1:0] = width_q;
         end
      end
   end

   assign reload_o = reload_q;
   assign ctrl_o   = ctrl_q;
   assign drv_o    = drv_q;
   assign width_o  = width_q;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int          CNT_W     = 32,
   parameter int          PRESC_DIV = 24,
   parameter logic [31:0] CNT_RST   = 32'h03EF1480
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   input  logic             slow_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   localparam int PR_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

   logic             slow_tick;
   logic             tick;
   logic [CNT_W-1:0] count_q;
   logic             armed_q;
   logic             expire_q;

   generate
      if (PRESC_DIV == 1) begin : g_no_presc
         assign slow_tick = 1'b1;
      end else begin : g_presc
         logic [PR_W-1:0] pr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pr_q <= '0;
            else if (load_i)                         pr_q <= '0;
            else if (pr_q == PR_W'(PRESC_DIV - 1))   pr_q <= '0;
            else                                     pr_q <= pr_q + 1'b1;
         end
         assign slow_tick = (pr_q == PR_W'(PRESC_DIV - 1));
      end
   endgenerate

   assign tick = slow_i ? slow_tick : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= CNT_RST[CNT_W-1:0];
         armed_q  <= 1'b0;
         expire_q <= 1'b0;
      end else begin
         expire_q <= 1'b0;
         if (load_i) begin
            count_q <= load_val_i;
            armed_q <= 1'b1;
         end else if (run_i && armed_q && tick) begin
            if (count_q <= CNT_W'(1)) begin
               count_q  <= '0;
               armed_q  <= 1'b0;
               expire_q <= 1'b1;
            end else begin
               count_q <= count_q - 1'b1;
            end
         end
      end
   end

   assign count_o  = count_q;
   assign expire_o = expire_q;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int PW_BITS   = 20,
   parameter int PRESC_DIV = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PW_BITS-1:0] width_i,
   input  logic               sys_sel_i,
   input  logic               ext_sel_i,
   input  logic               full_i,
   output logic               sys_act_o,
   output logic               ext_act_o,
   output logic               full_o
);

   localparam int PR_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

   logic               act_q;
   logic               sys_q, ext_q, full_q;
   logic [PW_BITS-1:0] left_q;
   logic               unit_tick;

   generate
      if (PRESC_DIV == 1) begin : g_no_presc
         assign unit_tick = 1'b1;
      end else begin : g_presc
         logic [PR_W-1:0] pr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pr_q <= '0;
            else if (start_i || !act_q)              pr_q <= '0;
            else if (pr_q == PR_W'(PRESC_DIV - 1))   pr_q <= '0;
            else                                     pr_q <= pr_q + 1'b1;
         end
         assign unit_tick = (pr_q == PR_W'(PRESC_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         left_q <= '0;
         sys_q  <= 1'b0;
         ext_q  <= 1'b0;
         full_q <= 1'b0;
      end else if (start_i) begin
         act_q  <= 1'b1;
         left_q <= (width_i == '0) ? PW_BITS'(1) : width_i;
         sys_q  <= sys_sel_i;
         ext_q  <= ext_sel_i;
         full_q <= full_i;
      end else if (act_q && unit_tick) begin
         left_q <= left_q - 1'b1;
         if (left_q == PW_BITS'(1)) act_q <= 1'b0;
      end
   end

   assign sys_act_o = act_q & sys_q;
   assign ext_act_o = act_q & ext_q;
   assign full_o    = act_q & sys_q & full_q;

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
   import wdog_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter int          ADDR_W     = 8,
   parameter int          CNT_W      = 32,
   parameter int          PW_BITS    = 20,
   parameter int          PRESC_DIV  = 24,
   parameter logic [31:0] RELOAD_RST = 32'h03EF1480,
   parameter logic [31:0] PW_RST     = 32'h000000FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              expire_o,
   output logic              irq_o,
   output logic              sys_rst_o,
   output logic              sys_rst_full_o,
   output logic              ext_rst_o,
   output logic              ext_rst_oe_o
);

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("wdog_ctrl: DATA_W must be 32");
      end
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("wdog_ctrl: ADDR_W must cover offset 0x18");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("wdog_ctrl: CNT_W out of range");
      end
      if (PW_BITS < 1 || PW_BITS > DATA_W - 8) begin : g_bad_pw_bits
         $error("wdog_ctrl: PW_BITS overlaps the key byte");
      end
      if (PRESC_DIV < 1) begin : g_bad_div
         $error("wdog_ctrl: PRESC_DIV must be at least 1");
      end
   endgenerate

   ctrl_t              ctrl_w;
   drv_t               drv_w;
   logic [CNT_W-1:0]   count_w;
   logic [CNT_W-1:0]   reload_w;
   logic [PW_BITS-1:0] width_w;
   logic               load_w;
   logic               expire_w;
   logic               ext_act_w;

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PW_BITS(PW_BITS),
      .RELOAD_RST(RELOAD_RST), .PW_RST(PW_RST)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .cur_count_i(count_w), .bus_rdata(bus_rdata),
      .reload_o(reload_w), .ctrl_o(ctrl_w), .drv_o(drv_w), .width_o(width_w),
      .load_o(load_w)
   );

   wdog_counter #(
      .CNT_W(CNT_W), .PRESC_DIV(PRESC_DIV), .CNT_RST(RELOAD_RST)
   ) cnt_i (
      .clk(clk), .rst_n(rst_n),
      .load_i(load_w), .load_val_i(reload_w),
      .run_i(ctrl_w.enable), .slow_i(ctrl_w.slow_tick),
      .count_o(count_w), .expire_o(expire_w)
   );

   wdog_pulse #(
      .PW_BITS(PW_BITS), .PRESC_DIV(PRESC_DIV)
   ) pulse_i (
      .clk(clk), .rst_n(rst_n),
      .start_i(expire_w), .width_i(width_w),
      .sys_sel_i(ctrl_w.sys_en), .ext_sel_i(ctrl_w.ext_en), .full_i(ctrl_w.full_chip),
      .sys_act_o(sys_rst_o), .ext_act_o(ext_act_w), .full_o(sys_rst_full_o)
   );

   assign expire_o     = expire_w;
   assign irq_o        = expire_w & ctrl_w.irq_en;
   assign ext_rst_o    = drv_w.pol_high ? ext_act_w : ~ext_act_w;
   assign ext_rst_oe_o = drv_w.push_pull | ext_act_w;

endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk #(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int CNT_W   = 32,
   parameter int PW_BITS = 20
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_en,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               expire_o,
   input logic               irq_o,
   input logic               sys_rst_o,
   input logic [CNT_W-1:0]   count_i,
   input logic [CNT_W-1:0]   reload_i,
   input logic [5:0]         ctrl_i,
   input logic [PW_BITS-1:0] width_i
);

   logic wr_restart_key, wr_ctrl_same, wr_pcfg, rd_restart;

   assign wr_restart_key = bus_en && bus_we && (bus_addr == ADDR_W'(8'h08))
                           && (bus_wdata[15:0] == 16'h4755);
   assign wr_ctrl_same   = bus_en && bus_we && (bus_addr == ADDR_W'(8'h0C))
                           && (bus_wdata[0] == ctrl_i[0]);
   assign wr_pcfg        = bus_en && bus_we && (bus_addr == ADDR_W'(8'h18));
   assign rd_restart     = bus_en && !bus_we && (bus_addr == ADDR_W'(8'h08));

   p_restart_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_restart_key |=> (count_i == $past(reload_i)));

   p_ctrl_unchanged_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl_same |=> $stable(ctrl_i));

   p_restart_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_restart |-> (bus_rdata == '0));

   p_width_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pcfg |=> (width_i == $past(bus_wdata[PW_BITS-1:0])));

   p_expire_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);

   p_expire_count_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |-> (count_i == '0));

   p_irq_with_expire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> expire_o);

   p_sys_after_expire_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_o) |-> $past(expire_o));

endmodule

bind wdog_ctrl wdog_ctrl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PW_BITS(PW_BITS)
) chk_i (
   .clk(clk), .rst_n(rst_n),
   .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .expire_o(expire_o), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
   .count_i(count_w), .reload_i(reload_w), .ctrl_i(ctrl_w), .width_i(width_w)
);

// File: tb/wdog_ctrl_tb.sv
module wdog_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        expire_o, irq_o, sys_rst_o, sys_rst_full_o, ext_rst_o, ext_rst_oe_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .expire_o(expire_o), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
      .sys_rst_full_o(sys_rst_full_o), .ext_rst_o(ext_rst_o), .ext_rst_oe_o(ext_rst_oe_o)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  waddr;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 20;
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 8'h00, 32'h0,        8'h00, 32'h03EF1480, 4'd7},  // R7 count
      '{1'b0, 8'h00, 32'h0,        8'h04, 32'h03EF1480, 4'd7},  // R7 reload
      '{1'b0, 8'h00, 32'h0,        8'h0C, 32'h0,        4'd7},  // R7 control
      '{1'b0, 8'h00, 32'h0,        8'h18, 32'h000000FF, 4'd7},  // R7 config
      '{1'b0, 8'h00, 32'h0,        8'h08, 32'h0,        4'd1},  // R1 restart reads 0
      '{1'b1, 8'h04, 32'h64,       8'h04, 32'h64,       4'd1},  // R1 reload rw
      '{1'b1, 8'h00, 32'h1234,     8'h00, 32'h03EF1480, 4'd1},  // R1 count read-only
      '{1'b1, 8'h08, 32'h4756,     8'h00, 32'h03EF1480, 4'd2},  // R2 wrong key
      '{1'b1, 8'h08, 32'hABCD4755, 8'h00, 32'h64,       4'd2},  // R2 key, upper ignored
      '{1'b1, 8'h18, 32'hA5000010, 8'h18, 32'h80000010, 4'd5},  // R5 active high
      '{1'b1, 8'h18, 32'hA8000020, 8'h18, 32'hC0000020, 4'd5},  // R5 push-pull
      '{1'b1, 8'h18, 32'h5A000030, 8'h18, 32'h40000030, 4'd5},  // R5 active low
      '{1'b1, 8'h18, 32'h8A0ABCDE, 8'h18, 32'h000ABCDE, 4'd6},  // R6 width, R5 open drain
      '{1'b1, 8'h18, 32'hA5000001, 8'h18, 32'h80000001, 4'd5},  // R5 active high again
      '{1'b1, 8'h18, 32'h33FFFFFF, 8'h18, 32'h800FFFFF, 4'd6},  // R6 other code, bits 29:20 zero
      '{1'b1, 8'h14, 32'hFFFFFFFF, 8'h14, 32'h0,        4'd1},  // R1 undefined offset
      '{1'b1, 8'h06, 32'hFFFFFFFF, 8'h04, 32'h64,       4'd1},  // R1 misaligned write ignored
      '{1'b0, 8'h00, 32'h0,        8'h05, 32'h0,        4'd1},  // R1 misaligned read
      '{1'b1, 8'h0C, 32'h0000003E, 8'h0C, 32'h0,        4'd4},  // R4 enable unchanged
      '{1'b1, 8'h10, 32'hFFFFFFFF, 8'h10, 32'h0,        4'd1}   // R1 undefined offset
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   // called in the low half of the clock; returns at the falling edge after the write edge
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_en = 1'b0;
   endtask

   task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_read(a, d);
      check(req, d, exp);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset values checked at the ports
      check("R7 expire", {31'b0, expire_o}, 32'h0);
      check("R7 sys_rst", {31'b0, sys_rst_o}, 32'h0);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [31:0] d;
         if (VECS[i].we) bus_write(VECS[i].waddr, VECS[i].wdata);
         bus_read(VECS[i].raddr, d);
         n_chk++;
         if (d !== VECS[i].exp) begin
            n_bad++;
            $display("FAIL R%0d vector %0d: actual 0x%08h expected 0x%08h",
                     VECS[i].req, i, d, VECS[i].exp);
         end
      end

      // A: exact expiry on fast tick, active-low open-drain external reset, width 3
      bus_write(8'h18, 32'h5A000003);
      check("R11 idle level low-active", {31'b0, ext_rst_o}, 32'h1);
      check("R11 idle oe open-drain", {31'b0, ext_rst_oe_o}, 32'h0);
      bus_write(8'h04, 32'd10);
      bus_write(8'h0C, 32'h0000000B);
      repeat (3) @(negedge clk);
      read_check("R3 fast tick count", 8'h00, 32'd7);
      repeat (6) @(negedge clk);
      check("R8 no expire before R", {31'b0, expire_o}, 32'h0);
      @(negedge clk);
      check("R8 expire at R", {31'b0, expire_o}, 32'h1);
      check("R9 irq off", {31'b0, irq_o}, 32'h0);
      check("R10 sys not yet", {31'b0, sys_rst_o}, 32'h0);
      @(negedge clk);
      check("R8 expire one cycle", {31'b0, expire_o}, 32'h0);
      check("R10 sys rises", {31'b0, sys_rst_o}, 32'h1);
      check("R10 soc mode", {31'b0, sys_rst_full_o}, 32'h0);
      check("R11 ext asserted low", {31'b0, ext_rst_o}, 32'h0);
      check("R11 oe while asserted", {31'b0, ext_rst_oe_o}, 32'h1);
      repeat (3*DIV - 1) @(negedge clk);
      check("R10 sys last cycle", {31'b0, sys_rst_o}, 32'h1);
      check("R11 ext last cycle", {31'b0, ext_rst_o}, 32'h0);
      @(negedge clk);
      check("R10 sys released", {31'b0, sys_rst_o}, 32'h0);
      check("R11 ext released", {31'b0, ext_rst_o}, 32'h1);
      check("R11 oe released", {31'b0, ext_rst_oe_o}, 32'h0);
      begin
         int extra = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (expire_o) extra++;
         end
         check("R8 no self restart", extra, 32'h0);
      end
      read_check("R8 count held at zero", 8'h00, 32'h0);
      bus_write(8'h0C, 32'h0);

      // D: wrong and right restart keys during a run, interrupt strobe
      bus_write(8'h0C, 32'h00000005);
      repeat (2) @(negedge clk);
      bus_write(8'h08, 32'h00004754);
      read_check("R2 wrong key while running", 8'h00, 32'd7);
      bus_write(8'h08, 32'h00004755);
      read_check("R2 key reloads", 8'h00, 32'd10);
      repeat (9) @(negedge clk);
      check("R8 no expire early", {31'b0, expire_o}, 32'h0);
      @(negedge clk);
      check("R9 irq with expire", {31'b0, irq_o}, 32'h1);
      @(negedge clk);
      check("R9 irq one cycle", {31'b0, irq_o}, 32'h0);
      check("R10 sys off when bit1 clear", {31'b0, sys_rst_o}, 32'h0);
      bus_write(8'h0C, 32'h0);

      // B: rewrite with same enable, then disable freezes
      bus_write(8'h04, 32'd20);
      bus_write(8'h0C, 32'h00000001);
      repeat (4) @(negedge clk);
      bus_write(8'h0C, 32'h00000011);
      read_check("R4 same-enable write ignored, fast tick kept", 8'h00, 32'd15);
      read_check("R4 control unchanged", 8'h0C, 32'h00000001);
      bus_write(8'h0C, 32'h0);
      repeat (5) @(negedge clk);
      read_check("R4 disable freezes count", 8'h00, 32'd14);
      bus_write(8'h08, 32'h00004755);
      repeat (3) @(negedge clk);
      read_check("R2 key while disabled loads, no count", 8'h00, 32'd20);

      // C: slow tick and full-chip mode
      bus_write(8'h04, 32'd2);
      bus_write(8'h0C, 32'h00000033);
      repeat (DIV - 1) @(negedge clk);
      read_check("R3 slow tick not yet", 8'h00, 32'd2);
      @(negedge clk);
      read_check("R3 slow tick decrement", 8'h00, 32'd1);
      repeat (DIV - 1) @(negedge clk);
      check("R3 slow expire not yet", {31'b0, expire_o}, 32'h0);
      @(negedge clk);
      check("R3 slow expire", {31'b0, expire_o}, 32'h1);
      @(negedge clk);
      check("R10 sys in slow mode", {31'b0, sys_rst_o}, 32'h1);
      check("R10 full-chip qualifier", {31'b0, sys_rst_full_o}, 32'h1);
      check("R11 ext off when bit3 clear", {31'b0, ext_rst_o}, 32'h1);
      repeat (3*DIV + 5) @(negedge clk);
      check("R10 full-chip cleared", {31'b0, sys_rst_full_o}, 32'h0);
      bus_write(8'h0C, 32'h0);

      // E: active-high push-pull, width 0 acts as 1
      bus_write(8'h18, 32'hA5000000);
      bus_write(8'h18, 32'hA8000000);
      check("R11 idle level high-active", {31'b0, ext_rst_o}, 32'h0);
      check("R11 push-pull oe idle", {31'b0, ext_rst_oe_o}, 32'h1);
      bus_write(8'h04, 32'd3);
      bus_write(8'h0C, 32'h00000009);
      repeat (3) @(negedge clk);
      check("R8 expire small reload", {31'b0, expire_o}, 32'h1);
      @(negedge clk);
      check("R11 ext asserted high", {31'b0, ext_rst_o}, 32'h1);
      check("R10 sys off when bit1 clear", {31'b0, sys_rst_o}, 32'h0);
      repeat (DIV - 1) @(negedge clk);
      check("R6 width zero lasts one unit", {31'b0, ext_rst_o}, 32'h1);
      @(negedge clk);
      check("R6 width zero released", {31'b0, ext_rst_o}, 32'h0);
      check("R11 push-pull oe after", {31'b0, ext_rst_oe_o}, 32'h1);

      done = 1'b1;
      finish_run();
   end

endmodule